// File: doc/BRIEF.md
# Settable Hour-Minute-Second Clock Controller

This block keeps the time of day as separate binary hour, minute and second counts and lets a user set it with two push keys. It runs entirely on a fast system clock. A slow once-per-second pulse, a mode key and a set key arrive as raw levels. Each one passes through a two-flop synchroniser and a rising-edge detector, so every rising edge becomes a single-cycle enable inside the clock domain.

A four-state mode machine decides which counters may move. After reset the block sits in an initialise state that shows 12:00:00. The mode key steps it to hour adjust, then to minute adjust, then to normal running, and from running back to hour adjust. In the two adjust modes the set key advances the selected field. In running mode the second pulse advances the time with carries, on a 12-hour dial that runs 1 to 12.

Top module: `hms_clock_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied and after it is released, the outputs read hour 12, minute 0 and second 0.
- R2: In the initialise mode, set key presses and second pulses leave all three outputs unchanged.
- R3: Each rising edge of the mode key steps the mode once, in the order initialise, hour adjust, minute adjust, running, and then from running back to hour adjust.
- R4: In hour adjust, each rising edge of the set key adds one to the hour, and 12 is followed by 1. Minute and second do not change.
- R5: In minute adjust, each rising edge of the set key adds one to the minute, and 59 is followed by 0. The hour is not changed by that wrap.
- R6: While the mode is minute adjust, the second output is held at 0.
- R7: In running mode, each rising edge of the second pulse adds one to the second, and 59 is followed by 0 with a carry into the minute.
- R8: In running mode, a minute carry at minute 59 wraps the minute to 0 and adds one to the hour, with 12 followed by 1.
- R9: Second pulses have no effect in either adjust mode, and set key presses have no effect in running mode.
- R10: A key held high for many clock cycles acts exactly once, on its rising edge.
- R11: The hour always lies in 1..12, and the minute and second always lie in 0..59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz_i | input | 1 | Raw once-per-second pulse; its rising edge advances the time in running mode |
| mode_key_i | input | 1 | Raw mode key level; its rising edge steps the mode |
| set_key_i | input | 1 | Raw set key level; its rising edge adjusts the selected field |
| hour_o | output | 4 | Binary hour, 1..12 |
| minute_o | output | 6 | Binary minute, 0..59 |
| second_o | output | 6 | Binary second, 0..59 |

## Verification
The mode register is not visible at the ports. A wrong mode therefore shows up only as the wrong field moving, or as no field moving, on the next key or second pulse. That happens three clock cycles after the raw edge, once the edge has crossed the synchroniser and the edge register. A broken carry shows up at a minute or hour boundary. For that reason the bench sweeps a full twelve-hour dial, comparing against times it computes from the elapsed seconds. The bench also checks every adjust step across both wrap points, and checks that a long key hold produces one step only.

// File: rtl/hms_pkg.sv
// Package: shared mode encoding for the clock controller.
// Assumes: two bits are enough for the four modes.
package hms_pkg;

    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,
        MODE_HOUR = 2'd1,
        MODE_MIN  = 2'd2,
        MODE_RUN  = 2'd3
    } hms_mode_e;

endpackage

// File: rtl/hms_edge_sync.sv
// Module: hms_edge_sync
// Brings one asynchronous level into the clock domain through STAGES flops.
// It then emits a one-cycle pulse on each rising edge of the synchronised level.
// Assumes: the raw input holds each level for at least one clock cycle.
module hms_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic pulse_o
);

    localparam int TOP = STAGES;

    logic [TOP:0] pipe_q;

    // Purpose: shift the raw level through the synchroniser and the edge register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[TOP-1:0], raw_i};
        end
    end

    // Purpose: flag the first cycle in which the synchronised level is high.
    always_comb begin
        pulse_o = pipe_q[TOP-1] & ~pipe_q[TOP];
    end

    // R10: a pulse never lasts two cycles in a row.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/hms_mode_fsm.sv
// Module: hms_mode_fsm
// Steps the operating mode once per advance pulse.
// The order is INIT -> HOUR -> MIN -> RUN -> HOUR, and INIT is never re-entered without reset.
// Assumes: adv_i is already a single-cycle synchronous pulse.
module hms_mode_fsm
    import hms_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv_i,
    output hms_mode_e mode_o
);

    hms_mode_e mode_q;
    hms_mode_e mode_d;

    // Purpose: choose the mode that follows the current one.
    always_comb begin
        mode_d = mode_q;
        if (adv_i) begin
            case (mode_q)
                MODE_INIT: mode_d = MODE_HOUR;
                MODE_HOUR: mode_d = MODE_MIN;
                MODE_MIN:  mode_d = MODE_RUN;
                default:   mode_d = MODE_HOUR;
            endcase
        end
    end

    // Purpose: hold the mode register; reset returns it to INIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_INIT;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;

    // R3: running mode steps back to hour adjust, never to initialise.
    a_r3_run_to_hour: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && adv_i) |=> (mode_q == MODE_HOUR));

    // R3: without an advance pulse the mode holds.
    a_r3_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(mode_q));

endmodule

// File: rtl/hms_wrap_counter.sv
// Module: hms_wrap_counter
// A bounded up-counter that runs from LO to HI and then wraps back to LO.
// A load input forces LOAD_VAL and takes priority over the increment.
// wrap_o marks an increment made while the value is at HI.
// Assumes: LO <= LOAD_VAL <= HI < 2**WIDTH.
module hms_wrap_counter #(
    parameter int WIDTH    = 6,
    parameter int LO       = 0,
    parameter int HI       = 59,
    parameter int LOAD_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] value_o,
    output logic             wrap_o
);

    localparam logic [WIDTH-1:0] LO_V   = WIDTH'(LO);
    localparam logic [WIDTH-1:0] HI_V   = WIDTH'(HI);
    localparam logic [WIDTH-1:0] LOAD_V = WIDTH'(LOAD_VAL);

    logic [WIDTH-1:0] value_q;

    // Purpose: flag an increment that passes the top of the range.
    always_comb begin
        wrap_o = inc_i && (value_q == HI_V);
    end

    // Purpose: load, wrap or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            value_q <= LOAD_V;
        end else if (inc_i) begin
            value_q <= (value_q == HI_V) ? LO_V : value_q + WIDTH'(1);
        end
    end

    assign value_o = value_q;

    // R11: the count never leaves its range.
    a_r11_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(value_q) >= LO) && (int'(value_q) <= HI));

endmodule

// File: rtl/hms_clock_ctrl.sv
// Module: hms_clock_ctrl (top)
// A settable 12-hour time keeper.
// Three edge synchronisers turn the second pulse and the two keys into single-cycle enables.
// A mode machine gates them onto the three chained counters.
// Assumes: clk is far faster than the key and second inputs toggle.
module hms_clock_ctrl
    import hms_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOUR_TOP    = 12,
    parameter int MIN_TOP     = 59,
    parameter int SEC_TOP     = 59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz_i,
    input  logic       mode_key_i,
    input  logic       set_key_i,
    output logic [3:0] hour_o,
    output logic [5:0] minute_o,
    output logic [5:0] second_o
);

    localparam int HOUR_W  = $clog2(HOUR_TOP + 1);
    localparam int MIN_W   = $clog2(MIN_TOP + 1);
    localparam int SEC_W   = $clog2(SEC_TOP + 1);
    localparam int N_INPUT = 3;
    localparam int IX_TICK = 0;
    localparam int IX_MODE = 1;
    localparam int IX_SET  = 2;

    logic [N_INPUT-1:0] raw_in;
    logic [N_INPUT-1:0] pulse;
    logic               tick_p;
    logic               mode_p;
    logic               set_p;
    hms_mode_e          mode;

    logic [HOUR_W-1:0]  hour_v;
    logic [MIN_W-1:0]   min_v;
    logic [SEC_W-1:0]   sec_v;
    logic               hour_wrap;
    logic               min_wrap;
    logic               sec_wrap;
    logic               hour_load;
    logic               hour_inc;
    logic               min_load;
    logic               min_inc;
    logic               sec_load;
    logic               sec_inc;

    assign raw_in = {set_key_i, mode_key_i, tick_1hz_i};

    // One synchroniser and edge detector per raw input.
    for (genvar g = 0; g < N_INPUT; g++) begin : g_sync
        hms_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_in[g]),
            .pulse_o (pulse[g])
        );
    end

    assign tick_p = pulse[IX_TICK];
    assign mode_p = pulse[IX_MODE];
    assign set_p  = pulse[IX_SET];

    hms_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (mode_p),
        .mode_o (mode)
    );

    // Purpose: route the enables to the counters that the current mode allows to move.
    always_comb begin
        sec_load  = (mode == MODE_INIT) || (mode == MODE_MIN);
        sec_inc   = (mode == MODE_RUN) && tick_p;
        min_load  = (mode == MODE_INIT);
        min_inc   = ((mode == MODE_RUN) && sec_wrap) || ((mode == MODE_MIN) && set_p);
        hour_load = (mode == MODE_INIT);
        hour_inc  = ((mode == MODE_RUN) && min_wrap) || ((mode == MODE_HOUR) && set_p);
    end

    hms_wrap_counter #(.WIDTH(SEC_W), .LO(0), .HI(SEC_TOP), .LOAD_VAL(0)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sec_load),
        .inc_i   (sec_inc),
        .value_o (sec_v),
        .wrap_o  (sec_wrap)
    );

    hms_wrap_counter #(.WIDTH(MIN_W), .LO(0), .HI(MIN_TOP), .LOAD_VAL(0)) u_min (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (min_load),
        .inc_i   (min_inc),
        .value_o (min_v),
        .wrap_o  (min_wrap)
    );

    hms_wrap_counter #(.WIDTH(HOUR_W), .LO(1), .HI(HOUR_TOP), .LOAD_VAL(HOUR_TOP)) u_hour (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (hour_load),
        .inc_i   (hour_inc),
        .value_o (hour_v),
        .wrap_o  (hour_wrap)
    );

    assign hour_o   = 4'(hour_v);
    assign minute_o = 6'(min_v);
    assign second_o = 6'(sec_v);

    // R2: the initialise mode keeps the 12:00:00 start value.
    a_r2_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INIT) |=> (hour_v == HOUR_W'(HOUR_TOP) && min_v == '0 && sec_v == '0));

    // R6: minute adjust pins the seconds to zero.
    a_r6_sec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MIN) |=> (sec_v == '0));

    // R5: a minute wrap during adjust leaves the hour alone.
    a_r5_no_hour_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MIN) |=> $stable(hour_v));

    // R9: in hour adjust, only a set pulse moves the hour.
    a_r9_hour_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOUR && !set_p) |=> $stable(hour_v));

    // R7: a second pulse in running mode below the top adds one.
    a_r7_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && tick_p && sec_v != SEC_W'(SEC_TOP))
        |=> (sec_v == $past(sec_v) + SEC_W'(1)));

    // R8: an hour increment caused by a carry never coincides with a nonzero minute afterwards.
    a_r8_carry_minute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && min_wrap) |=> (min_v == '0 && sec_v == '0));

    // Purpose: keep the top counter's wrap visible to the hour-range assertion.
    a_r11_hour_wrap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        hour_wrap |=> (hour_v == HOUR_W'(1)));

endmodule

// File: tb/test_hms_clock_ctrl.sv
module test_hms_clock_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mkey = 1'b0;
    logic       skey = 1'b0;
    logic [3:0] hour_o;
    logic [5:0] minute_o;
    logic [5:0] second_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int eh, em, es;

    always #4 clk = ~clk;

    hms_clock_ctrl i_hms_clock_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1hz_i (tick),
        .mode_key_i (mkey),
        .set_key_i  (skey),
        .hour_o     (hour_o),
        .minute_o   (minute_o),
        .second_o   (second_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req);
        checks = checks + 1;
        if (hour_o != 4'(eh) || minute_o != 6'(em) || second_o != 6'(es)) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d:%0d:%0d expected %0d:%0d:%0d",
                     req, hour_o, minute_o, second_o, eh, em, es);
        end
    endtask

    task automatic drive(input int which, input logic v);
        case (which)
            0: mkey = v;
            1: skey = v;
            default: tick = v;
        endcase
    endtask

    // A slow press: high for 4 cycles and low for 4, so the result is settled afterwards.
    task automatic press(input int which);
        @(negedge clk); drive(which, 1'b1);
        repeat (4) @(negedge clk);
        drive(which, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    // Fast second pulses: one cycle high, one low, then a settle wait.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        eh = 12; em = 0; es = 0;
        chk("R1 during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 after reset");
    endtask

    initial begin
        do_reset();

        // R2: the initialise mode ignores set and tick.
        press(1); chk("R2 set in init");
        ticks(3); chk("R2 tick in init");

        // R3: the first mode press goes to hour adjust.
        press(0);
        // R4: hour adjust steps through the wrap from 12 to 1.
        for (int i = 0; i < 14; i++) begin
            press(1);
            eh = (eh % 12) + 1;
            chk("R4 hour step");
        end
        // R9: tick ignored in hour adjust.
        ticks(5); chk("R9 tick in hour adjust");
        // R10: a long hold steps once.
        @(negedge clk); skey = 1'b1;
        repeat (20) @(negedge clk);
        eh = (eh % 12) + 1;
        chk("R10 long hold single step");
        skey = 1'b0; repeat (4) @(negedge clk);
        chk("R10 release no step");

        // R3: next press goes to minute adjust. R5: wrap without hour carry.
        press(0);
        for (int i = 0; i < 61; i++) begin
            press(1);
            em = (em + 1) % 60;
            chk("R5 minute step");
        end
        ticks(4); chk("R9 tick in minute adjust");

        // R3: next press goes to running mode. R7: single-second steps.
        press(0);
        for (int i = 0; i < 5; i++) begin
            ticks(1);
            es = es + 1;
            chk("R7 second step");
        end
        press(1); chk("R9 set in running mode");

        // R3: running goes back to hour adjust; the set key moves the hour.
        press(0);
        press(1); eh = (eh % 12) + 1; chk("R3 run to hour adjust");
        // R3 and R6: minute adjust zeros the nonzero seconds.
        press(0);
        es = 0; chk("R6 seconds forced to zero");
        press(1); em = (em + 1) % 60; chk("R3 hour to minute adjust");

        // R7 and R8: a full twelve-hour sweep from reset, checked once per minute.
        do_reset();
        press(0); press(0); press(0);
        chk("R3 reached running mode unchanged");
        for (int t = 1; t <= 720; t++) begin
            ticks(60);
            es = 0;
            em = t % 60;
            eh = (((t / 60) + 11) % 12) + 1;
            chk("R8 minute and hour carry");
        end
        ticks(59); es = 59; chk("R7 second 59");
        ticks(1);  es = 0; em = 1; chk("R7 second carry into minute");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule